// File: doc/BRIEF.md
# Memory Card Protocol State Tracker

This block sits on the card side of a serial memory-card link and follows the protocol state of the card. A command deserializer upstream presents one decoded command index per strobe, plus an address argument field. The block also takes status inputs: voltage presence, voltage compatibility, internal busy, bus arbitration result and start-bit detection. It moves through an identification sequence (idle, ready, identification) into the data-transfer side (stand-by, interrupt wait). It can drop into a terminal inactive state.

For each accepted command the block raises a one-cycle response-enable pulse. The response serializer uses that pulse to reply. For a command that is not allowed in the current state it raises a one-cycle illegal-command flag instead. It keeps the card's 16-bit relative address, which is written only during identification. Command indices are parameters, so a derivative protocol can renumber them without touching the logic.

Top module: `card_state_ctrl`

## Requirements
- R1: A valid command with the go-idle index (default 0) moves the card to idle from every state except inactive.
- R2: In idle, the operating-condition command (default index 1) with voltage present and not busy moves the card to ready with a response when compatible, and to inactive without a response when incompatible.
- R3: In idle, the operating-condition command with busy asserted or voltage absent keeps the card in idle. A response is given only if voltage is present.
- R4: In ready, the identification command (default index 2) moves the card to identification with a response when the bus is won. On a lost bus the card stays in ready with no response and no illegal flag.
- R5: In identification, the address command (default index 3) loads the 16-bit `cmd_arg` into the relative address, moves the card to stand-by and gives a response.
- R6: A valid go-inactive command (default index 15) moves the card to inactive from every state other than inactive.
- R7: In stand-by, the interrupt-mode command (default index 40) enters the interrupt-wait state with a response. In interrupt-wait, a start-bit pulse, or any valid command other than go-idle or go-inactive, returns the card to stand-by with no response.
- R8: Once inactive, the card ignores every command, go-idle included: no state change, no response, no illegal flag. Only reset leaves this state.
- R9: The relative address resets to zero and changes only as stated in R5.
- R10: A valid command not allowed in the current state leaves the state unchanged, gives no response and raises `illegal_cmd` for exactly one cycle.
- R11: All outputs are registered and change at the rising edge that samples `cmd_valid`. The state encoding is idle 0, ready 1, identification 2, stand-by 3, interrupt-wait 4, inactive 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 16 | Address field of the command argument |
| volt_present | input | 1 | Supply voltage present |
| volt_compat | input | 1 | Host voltage range is compatible |
| card_busy | input | 1 | Card is still powering up internally |
| bus_won | input | 1 | Card won identification arbitration |
| start_bit | input | 1 | Start bit seen on the bus |
| card_state | output | 3 | Current protocol state |
| resp_en | output | 1 | One-cycle response request |
| illegal_cmd | output | 1 | One-cycle illegal-command flag |
| rel_addr | output | 16 | Relative address register |

## Verification
The assertions assume that each command is a single-cycle `cmd_valid` pulse. They also assume that every status input holds a defined value in the cycle the strobe is sampled. They do not model two commands merging into one cycle, and they give a command precedence over a coincident start bit in interrupt-wait. The stimulus keeps within these assumptions. It changes every input only on the falling clock edge, gives each command exactly one cycle, and drives all inputs to known values from time zero through every reset.

// File: rtl/card_fsm_pkg.sv
package card_fsm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READY = 3'd1,
      ST_IDENT = 3'd2,
      ST_STBY  = 3'd3,
      ST_WIRQ  = 3'd4,
      ST_INACT = 3'd5
   } card_state_e;

   // positions in the command hit vector
   localparam int K_GO_IDLE  = 0;
   localparam int K_OP_COND  = 1;
   localparam int K_ALL_ID   = 2;
   localparam int K_SET_ADDR = 3;
   localparam int K_GO_INACT = 4;
   localparam int K_IRQ_MODE = 5;
   localparam int NUM_KNOWN  = 6;

endpackage

// File: rtl/card_cmd_decode.sv
module card_cmd_decode
   import card_fsm_pkg::*;
#(
   parameter int CMD_W       = 6,
   parameter int IX_GO_IDLE  = 0,
   parameter int IX_OP_COND  = 1,
   parameter int IX_ALL_ID   = 2,
   parameter int IX_SET_ADDR = 3,
   parameter int IX_GO_INACT = 15,
   parameter int IX_IRQ_MODE = 40
) (
   input  logic                 cmd_valid,
   input  logic [CMD_W-1:0]     cmd_index,
   output logic [NUM_KNOWN-1:0] hit
);

   localparam int IDX_TAB [NUM_KNOWN] = '{IX_GO_IDLE, IX_OP_COND, IX_ALL_ID,
                                          IX_SET_ADDR, IX_GO_INACT, IX_IRQ_MODE};
   localparam int IDX_LIMIT = 2 ** CMD_W;

   for (genvar i = 0; i < NUM_KNOWN; i++) begin : g_cmp
      assign hit[i] = cmd_valid && (cmd_index == CMD_W'(IDX_TAB[i]));

      if (IDX_TAB[i] < 0 || IDX_TAB[i] >= IDX_LIMIT) begin : g_range_bad
         $error("command index %0d does not fit in %0d bits", IDX_TAB[i], CMD_W);
      end

      for (genvar j = i + 1; j < NUM_KNOWN; j++) begin : g_uniq
         if (IDX_TAB[i] == IDX_TAB[j]) begin : g_dup
            $error("command index %0d assigned twice", IDX_TAB[i]);
         end
      end
   end

endmodule

// File: rtl/card_state_engine.sv
module card_state_engine
   import card_fsm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [NUM_KNOWN-1:0] hit,
   input  logic                 volt_present,
   input  logic                 volt_compat,
   input  logic                 card_busy,
   input  logic                 bus_won,
   input  logic                 start_bit,
   output card_state_e          state_q,
   output logic                 resp_q,
   output logic                 illegal_q,
   output logic                 addr_load
);

   card_state_e nxt;
   logic        resp_d;
   logic        ill_d;

   always_comb begin
      nxt       = state_q;
      resp_d    = 1'b0;
      ill_d     = 1'b0;
      addr_load = 1'b0;
      if (state_q != ST_INACT) begin
         if (hit[K_GO_IDLE]) begin
            nxt = ST_IDLE;
         end else if (hit[K_GO_INACT]) begin
            nxt = ST_INACT;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (hit[K_OP_COND]) begin
                     if (!volt_present) begin
                        nxt = ST_IDLE;
                     end else if (card_busy) begin
                        resp_d = 1'b1;
                     end else if (volt_compat) begin
                        nxt    = ST_READY;
                        resp_d = 1'b1;
                     end else begin
                        nxt = ST_INACT;
                     end
                  end else if (cmd_valid) begin
                     ill_d = 1'b1;
                  end
               end
               ST_READY: begin
                  if (hit[K_ALL_ID]) begin
                     if (bus_won) begin
                        nxt    = ST_IDENT;
                        resp_d = 1'b1;
                     end
                  end else if (cmd_valid) begin
                     ill_d = 1'b1;
                  end
               end
               ST_IDENT: begin
                  if (hit[K_SET_ADDR]) begin
                     nxt       = ST_STBY;
                     resp_d    = 1'b1;
                     addr_load = 1'b1;
                  end else if (cmd_valid) begin
                     ill_d = 1'b1;
                  end
               end
               ST_STBY: begin
                  if (hit[K_IRQ_MODE]) begin
                     nxt    = ST_WIRQ;
                     resp_d = 1'b1;
                  end else if (cmd_valid) begin
                     ill_d = 1'b1;
                  end
               end
               ST_WIRQ: begin
                  if (cmd_valid || start_bit) nxt = ST_STBY;
               end
               default: nxt = state_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         resp_q    <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         state_q   <= nxt;
         resp_q    <= resp_d;
         illegal_q <= ill_d;
      end
   end

   assert_go_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[K_GO_IDLE] && state_q != ST_INACT) |=> state_q == ST_IDLE);

   assert_op_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && hit[K_OP_COND] && volt_present && !card_busy && volt_compat)
      |=> (state_q == ST_READY && resp_q));

   assert_op_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && hit[K_OP_COND] && (card_busy || !volt_present))
      |=> state_q == ST_IDLE);

   assert_bus_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY && hit[K_ALL_ID] && !bus_won)
      |=> (state_q == ST_READY && !resp_q && !illegal_q));

   assert_go_inact_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[K_GO_INACT] && !hit[K_GO_IDLE] && state_q != ST_INACT) |=> state_q == ST_INACT);

   assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WIRQ && start_bit && !hit[K_GO_IDLE] && !hit[K_GO_INACT])
      |=> state_q == ST_STBY);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_INACT |=> (state_q == ST_INACT && !resp_q && !illegal_q));

   assert_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_q |-> (state_q == $past(state_q) && !resp_q));

endmodule

// File: rtl/card_addr_reg.sv
module card_addr_reg #(
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] ADDR_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] din,
   output logic [ADDR_W-1:0] addr_q
);

   if (ADDR_W < 1) begin : g_bad_w
      $error("address width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= ADDR_RST;
      else if (load) addr_q <= din;
   end

   assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(din));

   assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q));

endmodule

// File: rtl/card_state_ctrl.sv
module card_state_ctrl
   import card_fsm_pkg::*;
#(
   parameter int CMD_W       = 6,
   parameter int ADDR_W      = 16,
   parameter int IX_GO_IDLE  = 0,
   parameter int IX_OP_COND  = 1,
   parameter int IX_ALL_ID   = 2,
   parameter int IX_SET_ADDR = 3,
   parameter int IX_GO_INACT = 15,
   parameter int IX_IRQ_MODE = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_index,
   input  logic [ADDR_W-1:0] cmd_arg,
   input  logic              volt_present,
   input  logic              volt_compat,
   input  logic              card_busy,
   input  logic              bus_won,
   input  logic              start_bit,
   output logic [2:0]        card_state,
   output logic              resp_en,
   output logic              illegal_cmd,
   output logic [ADDR_W-1:0] rel_addr
);

   logic [NUM_KNOWN-1:0] hit;
   card_state_e          st;
   logic                 addr_load;

   card_cmd_decode #(
      .CMD_W(CMD_W), .IX_GO_IDLE(IX_GO_IDLE), .IX_OP_COND(IX_OP_COND),
      .IX_ALL_ID(IX_ALL_ID), .IX_SET_ADDR(IX_SET_ADDR),
      .IX_GO_INACT(IX_GO_INACT), .IX_IRQ_MODE(IX_IRQ_MODE)
   ) u_dec (
      .cmd_valid(cmd_valid),
      .cmd_index(cmd_index),
      .hit(hit)
   );

   card_state_engine u_eng (
      .clk(clk),
      .rst_n(rst_n),
      .cmd_valid(cmd_valid),
      .hit(hit),
      .volt_present(volt_present),
      .volt_compat(volt_compat),
      .card_busy(card_busy),
      .bus_won(bus_won),
      .start_bit(start_bit),
      .state_q(st),
      .resp_q(resp_en),
      .illegal_q(illegal_cmd),
      .addr_load(addr_load)
   );

   card_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk),
      .rst_n(rst_n),
      .load(addr_load),
      .din(cmd_arg),
      .addr_q(rel_addr)
   );

   assign card_state = st;

endmodule

// File: tb/sim_card_state_ctrl.sv
`timescale 1ns/1ps
module sim_card_state_ctrl;

   typedef struct packed {
      logic        v;
      logic [5:0]  ix;
      logic [15:0] arg;
      logic        pres, comp, busy, won, sb;
      logic [2:0]  es;
      logic        er, ei;
      logic [15:0] ea;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 6'd1,  16'h0,    1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b0, 16'h0,    4'd3},  // R3 no voltage
      '{1'b1, 6'd1,  16'h0,    1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0, 1'b1,1'b0, 16'h0,    4'd3},  // R3 busy
      '{1'b1, 6'd3,  16'h1111, 1'b1,1'b1,1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b1, 16'h0,    4'd10}, // R10 in idle
      '{1'b1, 6'd1,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd1, 1'b1,1'b0, 16'h0,    4'd2},  // R2 ready
      '{1'b1, 6'd2,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd1, 1'b0,1'b0, 16'h0,    4'd4},  // R4 lost
      '{1'b1, 6'd2,  16'h0,    1'b1,1'b1,1'b0,1'b1,1'b0, 3'd2, 1'b1,1'b0, 16'h0,    4'd4},  // R4 won
      '{1'b1, 6'd3,  16'hBEEF, 1'b1,1'b1,1'b0,1'b0,1'b0, 3'd3, 1'b1,1'b0, 16'hBEEF, 4'd5},  // R5
      '{1'b1, 6'd2,  16'h2222, 1'b1,1'b1,1'b0,1'b1,1'b0, 3'd3, 1'b0,1'b1, 16'hBEEF, 4'd10}, // R10 standby
      '{1'b0, 6'd3,  16'h3333, 1'b1,1'b1,1'b0,1'b0,1'b1, 3'd3, 1'b0,1'b0, 16'hBEEF, 4'd9},  // R9 no strobe
      '{1'b1, 6'd40, 16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd4, 1'b1,1'b0, 16'hBEEF, 4'd7},  // R7 enter
      '{1'b0, 6'd0,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd4, 1'b0,1'b0, 16'hBEEF, 4'd7},  // R7 wait
      '{1'b0, 6'd0,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b1, 3'd3, 1'b0,1'b0, 16'hBEEF, 4'd7},  // R7 start bit
      '{1'b1, 6'd40, 16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd4, 1'b1,1'b0, 16'hBEEF, 4'd7},  // R7 enter
      '{1'b1, 6'd7,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd3, 1'b0,1'b0, 16'hBEEF, 4'd7},  // R7 command wakes
      '{1'b1, 6'd0,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b0, 16'hBEEF, 4'd1},  // R1 standby
      '{1'b1, 6'd1,  16'h0,    1'b1,1'b0,1'b0,1'b0,1'b0, 3'd5, 1'b0,1'b0, 16'hBEEF, 4'd2},  // R2 incompatible
      '{1'b1, 6'd0,  16'h0,    1'b1,1'b1,1'b0,1'b0,1'b0, 3'd5, 1'b0,1'b0, 16'hBEEF, 4'd8},  // R8 go-idle ignored
      '{1'b1, 6'd1,  16'h0,    1'b1,1'b1,1'b0,1'b1,1'b1, 3'd5, 1'b0,1'b0, 16'hBEEF, 4'd8}   // R8 op ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [5:0]  cmd_index = '0;
   logic [15:0] cmd_arg = '0;
   logic        volt_present = 1'b0, volt_compat = 1'b0, card_busy = 1'b0;
   logic        bus_won = 1'b0, start_bit = 1'b0;
   logic [2:0]  card_state;
   logic        resp_en, illegal_cmd;
   logic [15:0] rel_addr;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   card_state_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
      .cmd_arg(cmd_arg), .volt_present(volt_present), .volt_compat(volt_compat),
      .card_busy(card_busy), .bus_won(bus_won), .start_bit(start_bit),
      .card_state(card_state), .resp_en(resp_en), .illegal_cmd(illegal_cmd),
      .rel_addr(rel_addr)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic [2:0] es, input logic er,
                            input logic ei, input logic [15:0] ea);
      check({req, " state"}, 16'(card_state), 16'(es));
      check({req, " resp"}, 16'(resp_en), 16'(er));
      check({req, " illegal"}, 16'(illegal_cmd), 16'(ei));
      check({req, " addr"}, rel_addr, ea);
   endtask

   // drive one cycle of stimulus at a falling edge, sample at the next one
   task automatic step(input logic v, input logic [5:0] ix, input logic [15:0] arg,
                       input logic pres, input logic comp, input logic busy,
                       input logic won, input logic sb);
      cmd_valid = v; cmd_index = ix; cmd_arg = arg;
      volt_present = pres; volt_compat = comp; card_busy = busy;
      bus_won = won; start_bit = sb;
      @(negedge clk);
      cmd_valid = 1'b0; start_bit = 1'b0;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      @(negedge clk);
      check_all("R11 reset", 3'd0, 1'b0, 1'b0, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check_all("R9 reset value", 3'd0, 1'b0, 1'b0, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         step(VEC[k].v, VEC[k].ix, VEC[k].arg, VEC[k].pres, VEC[k].comp,
              VEC[k].busy, VEC[k].won, VEC[k].sb);
         check_all($sformatf("R%0d vec%0d", VEC[k].req, k),
                   VEC[k].es, VEC[k].er, VEC[k].ei, VEC[k].ea);
      end

      // R8: only reset leaves inactive; R9: address back to zero
      do_reset();
      check_all("R8 after reset", 3'd0, 1'b0, 1'b0, 16'h0);

      // R6 from idle
      step(1'b1, 6'd15, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check_all("R6 idle", 3'd5, 1'b0, 1'b0, 16'h0);

      // R6 from identification, with a second address load first checked absent
      do_reset();
      step(1'b1, 6'd1, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 6'd2, 16'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      check_all("R4 won again", 3'd2, 1'b1, 1'b0, 16'h0);
      step(1'b1, 6'd15, 16'h5555, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check_all("R6 ident", 3'd5, 1'b0, 1'b0, 16'h0);

      // R5 new address, R7 then R1 out of interrupt-wait
      do_reset();
      step(1'b1, 6'd1, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 6'd2, 16'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b1, 6'd3, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check_all("R5 second load", 3'd3, 1'b1, 1'b0, 16'h1234);
      step(1'b1, 6'd40, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 6'd0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      check_all("R1 wait-irq", 3'd0, 1'b0, 1'b0, 16'h1234);

      // R10 flag lasts one cycle
      step(1'b1, 6'd40, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check_all("R10 pulse", 3'd0, 1'b0, 1'b1, 16'h1234);
      step(1'b0, 6'd0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check_all("R10 clears", 3'd0, 1'b0, 1'b0, 16'h1234);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule